// File: doc/BRIEF.md
# Compare-Clear Timer with Waveform Output

This block is an up-counting timer/counter that advances by one on each cycle where its count-enable strobe is high. The strobe stands for a prescaled tick generated elsewhere. The counter, the compare value and a small control field are loaded through a write-enable/address/data port. The current count and the compare value are driven out as outputs.

There are two behaviours. In free-running mode the counter climbs to all-ones and rolls over to zero. In compare-clear mode the compare value acts as the upper bound: the tick after the counter equals it returns the counter to zero. Two sticky flags report roll-over and compare match, and each has its own clear input. A single-bit waveform output reacts to compare matches according to a selectable action.

The compare value is used as soon as it is written, with no shadow copy. In compare-clear mode, a bound written below the running count is therefore missed until the counter rolls over and climbs back up to it.

Top module: `ctc_timer`

## Requirements
- R1: After reset the count, the compare value, both flags and the waveform output are all zero.
- R2: A write with address 0 loads the counter and address 1 loads the compare value. Address 2 loads the control field, with mode in data bits 1:0 and waveform action in bits 3:2. A write to address 3 changes nothing.
- R3: With mode 0, 1 or 3, every tick adds one to the counter, all-ones rolls over to zero, and a compare match never clears the counter.
- R4: With mode 2, a tick taken while the counter equals the compare value sets the counter to zero instead of incrementing it.
- R5: The roll-over flag is set by any tick that takes the counter from all-ones to zero, in any mode. Only its clear input resets it.
- R6: The match flag is set by a tick whose result equals the compare value. Only its clear input resets it.
- R7: In mode 2, if the compare value is written below the current count, no match occurs until the counter has passed all-ones, rolled over and climbed back to the compare value.
- R8: A clear input resets its flag on the next edge, unless a hardware set of that flag occurs in the same cycle, in which case the flag ends up set.
- R9: On a match, the waveform action sets the output as follows: action 0 leaves it unchanged, 1 inverts it, 2 drives it low and 3 drives it high. Without a match the output keeps its level.
- R10: A counter write in the same cycle as a tick wins: the counter takes the written value, and that value raises no match in that cycle.
- R11: With no tick and no counter write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | CNT_W | Write data |
| ovf_clr_i | input | 1 | Clears the roll-over flag |
| cmp_clr_i | input | 1 | Clears the match flag |
| cnt_o | output | CNT_W | Current count |
| cmp_o | output | CNT_W | Current compare value |
| ovf_flag_o | output | 1 | Sticky roll-over flag |
| cmp_flag_o | output | 1 | Sticky match flag |
| wave_o | output | 1 | Waveform output |

## Verification
The bench builds the block with the default CNT_W of 8. At that width a full roll-over takes 256 ticks, so the missed-bound path can be walked in one vector: roughly 240 ticks from a start above the bound, through all-ones, to the later match. The bench also covers the edge cases where the compare value is 0 and where it is all-ones. With a compare value of all-ones, the bound clear and the roll-over happen on the same tick.

// File: rtl/ctc_timer_pkg.sv
package ctc_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_RSV1 = 2'd1,
    MODE_CLR  = 2'd2,
    MODE_RSV3 = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_TOGL = 2'd1,
    ACT_LOW  = 2'd2,
    ACT_HIGH = 2'd3
  } wave_act_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/ctc_regs.sv
module ctc_regs
  import ctc_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cmp_o,
  output mode_e            mode_o,
  output wave_act_e        act_o,
  output logic             cnt_wr_o,
  output logic [CNT_W-1:0] cnt_wr_val_o
);
  logic [CNT_W-1:0] cmp_q;
  mode_e            mode_q;
  wave_act_e        act_q;

  logic wr_cmp, wr_ctrl;
  assign wr_cmp  = wr_en_i && (wr_addr_i == ADDR_CMP);
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      mode_q <= MODE_FREE;
      act_q  <= ACT_HOLD;
    end else begin
      if (wr_cmp) cmp_q <= wr_data_i;
      if (wr_ctrl) begin
        mode_q <= mode_e'(wr_data_i[1:0]);
        act_q  <= wave_act_e'(wr_data_i[3:2]);
      end
    end
  end

  assign cmp_o        = cmp_q;
  assign mode_o       = mode_q;
  assign act_o        = act_q;
  assign cnt_wr_o     = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign cnt_wr_val_o = wr_data_i;

  a_r2_cmp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp |=> cmp_o == $past(wr_data_i));
  a_r2_spare_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> ($stable(cmp_o) && $stable(mode_o) && $stable(act_o)));
endmodule

// File: rtl/ctc_counter.sv
module ctc_counter
  import ctc_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wr_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  mode_e            mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_step;
  logic             adv, at_top;

  // write wins over tick
  assign adv      = tick_i && !cnt_wr_i;
  assign at_top   = (mode_i == MODE_CLR) && (cnt_q == cmp_i);
  assign cnt_step = at_top ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= cnt_wr_val_i;
    else if (adv)      cnt_q <= cnt_step;
  end

  assign cnt_o   = cnt_q;
  assign match_o = adv && (cnt_step == cmp_i);
  assign wrap_o  = adv && (cnt_q == CNT_MAX);

  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_o == $past(cnt_wr_val_i));
  a_r4_clear_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && mode_i == MODE_CLR && cnt_o == cmp_i) |=> cnt_o == '0);
  a_r3_free_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && mode_i != MODE_CLR) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ctc_flag.sv
module ctc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
  import ctc_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      match_i,
  input  wave_act_e act_i,
  output logic      wave_o
);
  logic wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else if (match_i) begin
      unique case (act_i)
        ACT_HOLD: wave_q <= wave_q;
        ACT_TOGL: wave_q <= ~wave_q;
        ACT_LOW:  wave_q <= 1'b0;
        ACT_HIGH: wave_q <= 1'b1;
      endcase
    end
  end

  assign wave_o = wave_q;

  a_r9_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && act_i == ACT_TOGL) |=> wave_o != $past(wave_o));
  a_r9_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && act_i == ACT_LOW) |=> !wave_o);
  a_r9_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && act_i == ACT_HIGH) |=> wave_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i || act_i == ACT_HOLD) |=> $stable(wave_o));
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import ctc_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  input  logic             cmp_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o,
  output logic             wave_o
);
  localparam int N_FLAG = 2;

  mode_e            mode;
  wave_act_e        act;
  logic             cnt_wr, match, wrap;
  logic [CNT_W-1:0] cnt_wr_val, cmp_val;
  logic [N_FLAG-1:0] flag_set, flag_clr, flag_val;

  ctc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .cmp_o        (cmp_val),
    .mode_o       (mode),
    .act_o        (act),
    .cnt_wr_o     (cnt_wr),
    .cnt_wr_val_o (cnt_wr_val)
  );

  ctc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .cnt_wr_i     (cnt_wr),
    .cnt_wr_val_i (cnt_wr_val),
    .cmp_i        (cmp_val),
    .mode_i       (mode),
    .cnt_o        (cnt_o),
    .match_o      (match),
    .wrap_o       (wrap)
  );

  // bit 0: roll-over, bit 1: match
  assign flag_set = {match, wrap};
  assign flag_clr = {cmp_clr_i, ovf_clr_i};

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    ctc_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flag_val[g])
    );
  end

  ctc_wave u_wave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match),
    .act_i   (act),
    .wave_o  (wave_o)
  );

  assign cmp_o      = cmp_val;
  assign ovf_flag_o = flag_val[0];
  assign cmp_flag_o = flag_val[1];

  a_r5_wrap_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(wr_en_i && wr_addr_i == ADDR_CNT) && cnt_o == '1) |=> (ovf_flag_o && cnt_o == '0));
endmodule

// File: tb/test_ctc_timer.sv
module test_ctc_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  // {mode[43:42], cmp[41:34], start[33:26], ticks[25:10], exp_cnt[9:2], exp_ovf[1], exp_cf[0]}
  localparam int NVEC = 14;
  localparam logic [43:0] VEC [NVEC] = '{
    {2'd0, 8'h80, 8'h10, 16'd5,   8'h15, 1'b0, 1'b0}, // R3 plain count
    {2'd0, 8'h80, 8'hFE, 16'd3,   8'h01, 1'b1, 1'b0}, // R3 R5 roll-over
    {2'd0, 8'h12, 8'h10, 16'd2,   8'h12, 1'b0, 1'b1}, // R6 match
    {2'd0, 8'h12, 8'h10, 16'd5,   8'h15, 1'b0, 1'b1}, // R3 no clear in free mode
    {2'd2, 8'h05, 8'h03, 16'd2,   8'h05, 1'b0, 1'b1}, // R6 reach bound
    {2'd2, 8'h05, 8'h03, 16'd3,   8'h00, 1'b0, 1'b1}, // R4 clear, no roll-over
    {2'd2, 8'h05, 8'h03, 16'd5,   8'h02, 1'b0, 1'b1}, // R4 restart
    {2'd2, 8'h04, 8'h10, 16'd239, 8'hFF, 1'b0, 1'b0}, // R7 bound missed
    {2'd2, 8'h04, 8'h10, 16'd244, 8'h04, 1'b1, 1'b1}, // R7 match after wrap
    {2'd2, 8'hFF, 8'hFD, 16'd3,   8'h00, 1'b1, 1'b1}, // R4 R5 bound at all-ones
    {2'd1, 8'h05, 8'h03, 16'd3,   8'h06, 1'b0, 1'b1}, // R3 mode 1 free
    {2'd3, 8'h05, 8'h03, 16'd3,   8'h06, 1'b0, 1'b1}, // R3 mode 3 free
    {2'd2, 8'h00, 8'h00, 16'd2,   8'h00, 1'b0, 1'b1}, // R4 bound zero
    {2'd0, 8'h00, 8'hFF, 16'd1,   8'h00, 1'b1, 1'b1}  // R5 R6 wrap onto zero bound
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic ovf_clr_i = 1'b0;
  logic cmp_clr_i = 1'b0;
  logic [W-1:0] cnt_o, cmp_o;
  logic ovf_flag_o, cmp_flag_o, wave_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ctc_timer #(.CNT_W(W)) i_ctc_timer (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ovf_clr_i, .cmp_clr_i, .cnt_o, .cmp_o, .ovf_flag_o, .cmp_flag_o, .wave_o
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] addr, input logic [W-1:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk_i);
    ovf_clr_i = 1'b1; cmp_clr_i = 1'b1;
    @(negedge clk_i);
    ovf_clr_i = 1'b0; cmp_clr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cnt", 16'(cnt_o), 16'h0);
    chk("R1 cmp", 16'(cmp_o), 16'h0);
    chk("R1 flags", 16'({ovf_flag_o, cmp_flag_o}), 16'h0);
    chk("R1 wave", 16'(wave_o), 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      wr(2'd2, {6'd0, VEC[i][43:42]});
      wr(2'd1, VEC[i][41:34]);
      wr(2'd0, VEC[i][33:26]);
      clr_flags();
      ticks(int'(VEC[i][25:10]));
      chk($sformatf("R3/R4 vec%0d cnt", i), 16'(cnt_o), 16'(VEC[i][9:2]));
      chk($sformatf("R5 vec%0d ovf", i), 16'(ovf_flag_o), 16'(VEC[i][1]));
      chk($sformatf("R6 vec%0d match", i), 16'(cmp_flag_o), 16'(VEC[i][0]));
    end

    // R2 load paths and spare address
    wr(2'd1, 8'h33);
    wr(2'd0, 8'h44);
    chk("R2 cmp load", 16'(cmp_o), 16'h33);
    chk("R2 cnt load", 16'(cnt_o), 16'h44);
    wr(2'd3, 8'hAA);
    chk("R2 spare addr cnt", 16'(cnt_o), 16'h44);
    chk("R2 spare addr cmp", 16'(cmp_o), 16'h33);

    // R11 hold without tick
    repeat (5) @(negedge clk_i);
    chk("R11 hold", 16'(cnt_o), 16'h44);

    // R10 write beats tick, written match value raises no flag
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h30);
    clr_flags();
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h40;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    chk("R10 cnt", 16'(cnt_o), 16'h40);
    chk("R10 no match", 16'(cmp_flag_o), 16'h0);
    ticks(1);
    chk("R10 resume", 16'(cnt_o), 16'h41);

    // R8 set beats clear
    wr(2'd0, 8'h3F);
    clr_flags();
    @(negedge clk_i);
    tick_i = 1'b1; cmp_clr_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0; cmp_clr_i = 1'b0;
    chk("R8 set wins", 16'(cmp_flag_o), 16'h1);
    @(negedge clk_i);
    cmp_clr_i = 1'b1;
    @(negedge clk_i);
    cmp_clr_i = 1'b0;
    chk("R8 clear", 16'(cmp_flag_o), 16'h0);
    wr(2'd0, 8'hFF);
    @(negedge clk_i);
    tick_i = 1'b1; ovf_clr_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0; ovf_clr_i = 1'b0;
    chk("R8 ovf set wins", 16'(ovf_flag_o), 16'h1);

    // R9 waveform actions, bound 2 in clear mode
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h06);  // mode 2, toggle
    wr(2'd0, 8'h00);
    ticks(1);
    chk("R9 before match", 16'(wave_o), 16'h0);
    ticks(1);
    chk("R9 toggle up", 16'(wave_o), 16'h1);
    ticks(3);
    chk("R9 toggle down", 16'(wave_o), 16'h0);
    wr(2'd2, 8'h0E);  // high
    wr(2'd0, 8'h00);
    ticks(2);
    chk("R9 high", 16'(wave_o), 16'h1);
    wr(2'd2, 8'h02);  // hold
    wr(2'd0, 8'h00);
    ticks(2);
    chk("R9 hold", 16'(wave_o), 16'h1);
    wr(2'd2, 8'h0A);  // low
    wr(2'd0, 8'h00);
    ticks(2);
    chk("R9 low", 16'(wave_o), 16'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule